// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a two-wire serial bus slave that gives a host controller access to a bank of sixteen byte-wide control registers. The host addresses the slave with a fixed 7-bit device address followed by a direction bit. It then sends a 4-bit register pointer. After that it either writes data bytes, or issues a repeated start and reads data bytes. The pointer advances after every data byte and wraps from the last register to the first, so one transfer can cover any run of registers.

The stored register contents are presented continuously on a flat output vector that drives the rest of the chip. Three status inputs are returned as read-only bits during reads. Two registers together carry a 15-bit divide word. That word reaches its own output only after both of its halves have been written, in either order, so the divider never sees a half-updated value. Writing the self-clearing clear bit restores every register to its reset value, and the byte that carried the bit is refused.

The bus lines arrive already sampled into the block clock domain. The slave acknowledges and returns read data by asserting an open-drain pull-down enable.

Bus sequencer states:
- S_IDLE waits for a start condition.
- S_ADDR shifts in the device byte.
- S_SUB shifts in the pointer.
- S_WDATA shifts in write data.
- S_ACK holds the acknowledge for one bus clock.
- S_RDATA shifts out read data.
- S_MACK samples the host's acknowledge.
- S_IGNORE waits for a stop.

Sequencer transitions:
- From any state, stop or sleep goes to S_IDLE, and start goes to S_ADDR.
- S_ADDR goes to S_ACK on an address match, otherwise to S_IGNORE.
- S_SUB always goes to S_ACK at the end of its byte.
- S_WDATA goes to S_ACK, or to S_IDLE when the byte sets the clear bit.
- S_ACK goes to S_SUB, S_WDATA or S_RDATA.
- S_RDATA goes to S_MACK.
- S_MACK goes to S_RDATA on an acknowledge, or to S_IGNORE on a not-acknowledge.

Top module: `i2c_rf_top`

## Requirements
- R1: Only a device byte whose upper seven bits are 0x60 is acknowledged. 0xC0 selects a write and 0xC1 (bit 0 = 1) selects a read. Any other device byte receives no acknowledge, and nothing in the transfer that follows changes a register.
- R2: In a write transfer (start, 0xC0, pointer, data), every byte is acknowledged. The data byte lands in the register named by the low 4 bits of the pointer. Its slice ctrl_o[8*n+7:8*n] shows the new value one clock after the SCL fall that ends the eighth data bit.
- R3: In a write transfer, each further data byte goes to the next register. The pointer wraps from 0xF to 0x0.
- R4: A read transfer is start, 0xC0, pointer, repeated start, 0xC1. It returns register contents MSB first and advances the pointer, wrapping from 0xF to 0x0, for as long as the host acknowledges. A not-acknowledge from the host ends the read.
- R5: Bit 7 of registers 0x0, 0x7 and 0x8 is read-only. On a read it returns stat_i[0], stat_i[1] and stat_i[2] respectively. Writes to these bits are dropped, and they read 0 on ctrl_o.
- R6: div_o is {reg0[6:0], reg1}. It takes the new value two clocks after the SCL fall ending the second of the two bytes, whichever was written first. Writing only one of the two registers leaves div_o unchanged.
- R7: A write of a byte with bit 6 set to register 0xF returns every register to its reset value. That byte is not acknowledged, and bit 6 reads back 0. The state of a divider half already written is discarded, and div_o returns to 0.
- R8: After reset:
  - register 0x4 holds 0x02;
  - register 0x5 holds 0x3C;
  - register 0x6 holds 0x08;
  - register 0x7 holds 0x38;
  - register 0xF holds 0x80;
  - every other register holds 0x00;
  - div_o is 0.
- R9: While sleep_i is high, the slave acknowledges nothing and changes no register.
- R10: A stop in the middle of a byte ends the transfer with no register changed. A start in the middle of a byte discards the partial byte and begins a new device byte.
- R11: sda_pull_o changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| sleep_i | input | 1 | High puts the bus interface to sleep |
| stat_i | input | 3 | Live status bits returned on reads |
| sda_pull_o | output | 1 | Pull-down enable for the data line |
| ctrl_o | output | 128 | Register n in bits 8n+7 down to 8n |
| div_o | output | 15 | Committed divide word |

## Verification
The bench drives the bus on falling clock edges. A register write therefore appears on ctrl_o after the next rising edge. The divide word follows one clock later, and the acknowledge pull-down is asserted one clock after the SCL fall. The reference model applies each register write at the instant the bench drops SCL on the eighth bit, and applies the divider commit one clock after that. Every clock, a comparison made 3 ns after the rising edge matches ctrl_o and div_o against the model with no slack. Acknowledge bits and read data are sampled at the end of the SCL high phase, well after they have settled.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
    localparam int RF_NREG    = 16;
    localparam int RF_DW      = 8;
    localparam int RF_AW      = $clog2(RF_NREG);
    localparam int RF_DIVW    = 2 * RF_DW - 1;
    localparam int RF_DIV_HI  = 0;
    localparam int RF_DIV_LO  = 1;
    localparam int RF_CLR_REG = 15;
    localparam int RF_CLR_BIT = 6;
    localparam int RF_ST_BIT  = 7;
    localparam int RF_ST_A    = 0;
    localparam int RF_ST_B    = 7;
    localparam int RF_ST_C    = 8;

    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_SUB, S_WDATA, S_ACK, S_RDATA, S_MACK, S_IGNORE
    } bus_state_t;

    function automatic logic [RF_DW-1:0] rf_default(input int idx);
        logic [RF_DW-1:0] v;
        v = '0;
        case (idx)
            4:       v = 8'h02;
            5:       v = 8'h3C;
            6:       v = 8'h08;
            7:       v = 8'h38;
            15:      v = 8'h80;
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic logic rf_is_status(input int idx);
        return (idx == RF_ST_A) || (idx == RF_ST_B) || (idx == RF_ST_C);
    endfunction
endpackage

// File: rtl/i2c_rf_edges.sv
module i2c_rf_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic rise_o,
    output logic fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign rise_o  = scl_i && !scl_q;
    assign fall_o  = !scl_i && scl_q;
    assign start_o = scl_i && scl_q && sda_q && !sda_i;
    assign stop_o  = scl_i && scl_q && !sda_q && sda_i;
endmodule

// File: rtl/i2c_rf_regs.sv
module i2c_rf_regs
    import i2c_rf_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       wr_en,
    input  logic [RF_AW-1:0]           wr_addr,
    input  logic [RF_DW-1:0]           wr_data,
    input  logic [RF_AW-1:0]           rd_addr,
    input  logic [2:0]                 stat_i,
    output logic [RF_DW-1:0]           rd_data,
    output logic [RF_NREG*RF_DW-1:0]   bank_o,
    output logic [RF_DIVW-1:0]         div_o
);
    logic [RF_DW-1:0] bank [RF_NREG];
    logic hi_f, lo_f;

    function automatic logic [RF_DW-1:0] wmask(input logic [RF_AW-1:0] a);
        logic [RF_DW-1:0] m;
        m = '1;
        if (rf_is_status(int'(a))) m[RF_ST_BIT] = 1'b0;
        return m;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < RF_NREG; i++) bank[i] <= rf_default(i);
        end else if (clr) begin
            for (int i = 0; i < RF_NREG; i++) bank[i] <= rf_default(i);
        end else if (wr_en) begin
            bank[wr_addr] <= wr_data & wmask(wr_addr);
        end
    end

    // divider staging: commit once both halves were written
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_f <= 1'b0;
            lo_f <= 1'b0;
            div_o <= '0;
        end else if (clr) begin
            hi_f <= 1'b0;
            lo_f <= 1'b0;
            div_o <= '0;
        end else if (hi_f && lo_f) begin
            div_o <= {bank[RF_DIV_HI][RF_DW-2:0], bank[RF_DIV_LO]};
            hi_f <= 1'b0;
            lo_f <= 1'b0;
        end else if (wr_en) begin
            if (int'(wr_addr) == RF_DIV_HI) hi_f <= 1'b1;
            if (int'(wr_addr) == RF_DIV_LO) lo_f <= 1'b1;
        end
    end

    always_comb begin
        rd_data = bank[rd_addr];
        if (int'(rd_addr) == RF_ST_A) rd_data[RF_ST_BIT] = stat_i[0];
        if (int'(rd_addr) == RF_ST_B) rd_data[RF_ST_BIT] = stat_i[1];
        if (int'(rd_addr) == RF_ST_C) rd_data[RF_ST_BIT] = stat_i[2];
    end

    for (genvar g = 0; g < RF_NREG; g++) begin : g_flat
        assign bank_o[g*RF_DW +: RF_DW] = bank[g];
    end

    p_div_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_o) |-> ($past(hi_f && lo_f) || $past(clr)));

    p_clr_defaults_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!bank[RF_CLR_REG][RF_CLR_BIT] && bank[5] == 8'h3C && div_o == '0));
endmodule

// File: rtl/i2c_rf_top.sv
module i2c_rf_top
    import i2c_rf_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h60
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scl_i,
    input  logic                      sda_i,
    input  logic                      sleep_i,
    input  logic [2:0]                stat_i,
    output logic                      sda_pull_o,
    output logic [RF_NREG*RF_DW-1:0]  ctrl_o,
    output logic [RF_DIVW-1:0]        div_o
);
    localparam int BCW = $clog2(RF_DW + 1);

    logic rise_e, fall_e, start_e, stop_e;
    bus_state_t state, nxt, ack_next;
    logic [RF_DW-1:0] shreg, rd_data;
    logic [BCW-1:0]   cnt;
    logic [RF_AW-1:0] sub;
    logic nack, byte_end, addr_hit, wr_en, soft_clr;

    i2c_rf_edges u_edges (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .rise_o(rise_e), .fall_o(fall_e), .start_o(start_e), .stop_o(stop_e)
    );

    assign byte_end = fall_e && (cnt == BCW'(RF_DW));
    assign addr_hit = (shreg[RF_DW-1:1] == DEV_ADDR);
    assign wr_en    = (state == S_WDATA) && byte_end && !sleep_i;
    assign soft_clr = wr_en && (int'(sub) == RF_CLR_REG) && shreg[RF_CLR_BIT];

    i2c_rf_regs u_regs (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr), .wr_en(wr_en),
        .wr_addr(sub), .wr_data(shreg), .rd_addr(sub), .stat_i(stat_i),
        .rd_data(rd_data), .bank_o(ctrl_o), .div_o(div_o)
    );

    always_comb begin
        nxt = state;
        if (sleep_i || stop_e) begin
            nxt = S_IDLE;
        end else if (start_e) begin
            nxt = S_ADDR;
        end else begin
            unique case (state)
                S_ADDR:  if (byte_end) nxt = addr_hit ? S_ACK : S_IGNORE;
                S_SUB:   if (byte_end) nxt = S_ACK;
                S_WDATA: if (byte_end) nxt = soft_clr ? S_IDLE : S_ACK;
                S_ACK:   if (fall_e)   nxt = ack_next;
                S_RDATA: if (byte_end) nxt = S_MACK;
                S_MACK:  if (fall_e)   nxt = nack ? S_IGNORE : S_RDATA;
                default: nxt = state;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            cnt      <= '0;
            sub      <= '0;
            nack     <= 1'b1;
            ack_next <= S_IDLE;
        end else if (sleep_i || start_e || stop_e || soft_clr) begin
            cnt <= '0;
            if (soft_clr) sub <= '0;
        end else begin
            unique case (state)
                S_ADDR, S_SUB, S_WDATA: begin
                    if (rise_e) begin
                        shreg <= {shreg[RF_DW-2:0], sda_i};
                        cnt   <= cnt + 1'b1;
                    end else if (byte_end) begin
                        cnt <= '0;
                        if (state == S_ADDR) begin
                            ack_next <= shreg[0] ? S_RDATA : S_SUB;
                        end else if (state == S_SUB) begin
                            sub      <= shreg[RF_AW-1:0];
                            ack_next <= S_WDATA;
                        end else begin
                            sub      <= sub + 1'b1;
                            ack_next <= S_WDATA;
                        end
                    end
                end
                S_ACK: if (fall_e) begin
                    shreg <= rd_data;
                    cnt   <= '0;
                end
                S_RDATA: begin
                    if (rise_e) begin
                        cnt <= cnt + 1'b1;
                    end else if (byte_end) begin
                        cnt <= '0;
                        sub <= sub + 1'b1;
                    end else if (fall_e) begin
                        shreg <= {shreg[RF_DW-2:0], 1'b1};
                    end
                end
                S_MACK: begin
                    if (rise_e) begin
                        nack <= sda_i;
                    end else if (fall_e) begin
                        shreg <= rd_data;
                        cnt   <= '0;
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            S_ACK:   sda_pull_o = 1'b1;
            S_RDATA: sda_pull_o = !shreg[RF_DW-1];
            default: sda_pull_o = 1'b0;
        endcase
    end

    p_foreign_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADDR && byte_end && !addr_hit && !sleep_i) |=> (state == S_IGNORE));

    p_sleep_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> (state == S_IDLE && !sda_pull_o));

    p_pull_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n || sleep_i)
        !$stable(sda_pull_o) |-> !scl_i);
endmodule

// File: tb/sim_i2c_rf_top.sv
module sim_i2c_rf_top;
    import i2c_rf_pkg::*;

    localparam int H = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, scl_m, sda_m, sleep;
    logic [2:0] stat;
    logic sda_pull;
    logic [127:0] ctrl;
    logic [14:0] div;
    logic sda_bus;
    assign sda_bus = sda_m & ~sda_pull;

    i2c_rf_top u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sleep_i(sleep), .stat_i(stat), .sda_pull_o(sda_pull),
        .ctrl_o(ctrl), .div_o(div)
    );

    int n_chk = 0, n_bad = 0;
    bit run = 0, done = 0;
    logic [7:0] shadow [16];
    bit hi_p, lo_p;
    logic [14:0] mdiv;
    logic [127:0] exp_flat;
    logic prev_pull = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 16; i++) shadow[i] = 8'h00;
        shadow[4] = 8'h02; shadow[5] = 8'h3C; shadow[6] = 8'h08;
        shadow[7] = 8'h38; shadow[15] = 8'h80;
        hi_p = 0; lo_p = 0; mdiv = '0;
    endtask

    task automatic mwrite(input logic [3:0] a, input logic [7:0] d);
        logic [7:0] v;
        v = d;
        if (a == 4'hF && d[6]) begin
            model_reset();
            return;
        end
        if (a == 4'h0 || a == 4'h7 || a == 4'h8) v[7] = 1'b0;
        shadow[a] = v;
        if (a == 4'h0) hi_p = 1;
        if (a == 4'h1) lo_p = 1;
    endtask

    task automatic mcommit();
        if (hi_p && lo_p) begin
            mdiv = {shadow[0][6:0], shadow[1]};
            hi_p = 0; lo_p = 0;
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [3:0] a);
        logic [7:0] v;
        v = shadow[a];
        if (a == 4'h0) v[7] = stat[0];
        if (a == 4'h7) v[7] = stat[1];
        if (a == 4'h8) v[7] = stat[2];
        return v;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1; tick(H); scl_m = 1; tick(H); sda_m = 0; tick(H); scl_m = 0; tick(H);
    endtask

    task automatic bus_stop();
        sda_m = 0; tick(H); scl_m = 1; tick(H); sda_m = 1; tick(H);
    endtask

    task automatic send_bits(input logic [7:0] d, input int n);
        for (int i = 0; i < n; i++) begin
            sda_m = d[7-i]; tick(H); scl_m = 1; tick(H); scl_m = 0; tick(H);
        end
    endtask

    task automatic send_byte(input logic [7:0] d, input bit wr, input logic [3:0] a, output bit ack);
        for (int i = 0; i < 8; i++) begin
            sda_m = d[7-i]; tick(H); scl_m = 1; tick(H); scl_m = 0;
            if (i == 7 && wr) mwrite(a, d);
            tick(1);
            if (i == 7 && wr) mcommit();
            tick(H - 1);
        end
        sda_m = 1; tick(H); scl_m = 1; tick(H);
        ack = !sda_bus;
        scl_m = 0; tick(H);
    endtask

    task automatic read_byte(input bit mack, output logic [7:0] d);
        for (int i = 0; i < 8; i++) begin
            tick(H); scl_m = 1; tick(H);
            d[7-i] = sda_bus;
            scl_m = 0;
        end
        sda_m = !mack; tick(H); scl_m = 1; tick(H); scl_m = 0; tick(1); sda_m = 1; tick(H - 1);
    endtask

    task automatic write_regs(input string tag, input logic [3:0] a, input logic [7:0] q[$]);
        bit ack, clr;
        logic [3:0] cur;
        cur = a;
        bus_start();
        send_byte(8'hC0, 0, 0, ack); check({tag, " addr ack"}, ack, !sleep);
        send_byte({4'h0, a}, 0, 0, ack); check({tag, " ptr ack"}, ack, !sleep);
        foreach (q[k]) begin
            clr = (cur == 4'hF) && q[k][6] && !sleep;
            send_byte(q[k], !sleep, cur, ack);
            check({tag, " data ack"}, ack, !sleep && !clr);
            if (clr) break;
            cur = cur + 1'b1;
        end
        bus_stop();
    endtask

    task automatic read_regs(input string tag, input logic [3:0] a, input int n);
        bit ack;
        logic [7:0] d;
        logic [3:0] cur;
        cur = a;
        bus_start();
        send_byte(8'hC0, 0, 0, ack); check({tag, " addr ack"}, ack, 1);
        send_byte({4'h0, a}, 0, 0, ack); check({tag, " ptr ack"}, ack, 1);
        bus_start();
        send_byte(8'hC1, 0, 0, ack); check({tag, " read addr ack"}, ack, 1);
        for (int k = 0; k < n; k++) begin
            read_byte(k != n - 1, d);
            check({tag, " read data"}, d, exp_rd(cur));
            cur = cur + 1'b1;
        end
        bus_stop();
    endtask

    // per-clock comparison against the model (R2, R6, R11)
    always @(posedge clk) begin
        #3;
        if (run) begin
            for (int i = 0; i < 16; i++) exp_flat[i*8 +: 8] = shadow[i];
            n_chk++;
            if (ctrl !== exp_flat) begin
                n_bad++;
                $display("FAIL R2 ctrl_o act=%h exp=%h", ctrl, exp_flat);
            end
            n_chk++;
            if (div !== mdiv) begin
                n_bad++;
                $display("FAIL R6 div_o act=%h exp=%h", div, mdiv);
            end
            n_chk++;
            if (sda_pull !== prev_pull && scl_m) begin
                n_bad++;
                $display("FAIL R11 pull changed with SCL high act=%b exp=%b", sda_pull, prev_pull);
            end
            prev_pull = sda_pull;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit ack;
        rst_n = 0; scl_m = 1; sda_m = 1; sleep = 0; stat = 3'b000;
        model_reset();
        tick(5);
        rst_n = 1;
        tick(2);
        run = 1;

        // R8 reset values
        check("R8 reg5", ctrl[5*8 +: 8], 8'h3C);
        check("R8 regF", ctrl[15*8 +: 8], 8'h80);
        check("R8 reg7", ctrl[7*8 +: 8], 8'h38);
        check("R8 div", div, 0);

        // R1 foreign device address
        bus_start();
        send_byte(8'hA0, 0, 0, ack); check("R1 foreign addr nack", ack, 0);
        send_byte(8'h02, 0, 0, ack); check("R1 foreign ptr nack", ack, 0);
        send_byte(8'h99, 0, 0, ack); check("R1 foreign data nack", ack, 0);
        bus_stop();
        check("R1 reg2 untouched", ctrl[2*8 +: 8], 8'h00);

        // R2 single write
        write_regs("R2", 4'h2, '{8'h5A});
        check("R2 reg2", ctrl[2*8 +: 8], 8'h5A);

        // R3 sequential write with wrap; also R6 commit hi then lo
        write_regs("R3", 4'hE, '{8'h11, 8'hA0, 8'h12, 8'h34});
        check("R3 wrap reg0", ctrl[0 +: 8], 8'h12);
        check("R6 div hi-lo", div, 15'h1234);

        // R6 lo first, then hi
        write_regs("R6", 4'h1, '{8'h56});
        check("R6 one half only", div, 15'h1234);
        write_regs("R6", 4'h0, '{8'h05});
        check("R6 div lo-hi", div, 15'h0556);

        // R5 read-only bits
        write_regs("R5", 4'h7, '{8'hFF, 8'hC3});
        check("R5 reg7 bit7 dropped", ctrl[7*8 +: 8], 8'h7F);
        check("R5 reg8 bit7 dropped", ctrl[8*8 +: 8], 8'h43);
        stat = 3'b101;
        read_regs("R5", 4'h7, 2);
        read_regs("R5", 4'h0, 1);
        stat = 3'b010;
        read_regs("R5", 4'h7, 2);

        // R4 sequential read across wrap, then single read
        read_regs("R4", 4'hE, 4);
        read_regs("R4", 4'h5, 1);

        // R10 stop mid-byte
        bus_start();
        send_byte(8'hC0, 0, 0, ack); check("R10 addr ack", ack, 1);
        send_byte(8'h03, 0, 0, ack); check("R10 ptr ack", ack, 1);
        send_bits(8'hEE, 4);
        bus_stop();
        check("R10 stop abort reg3", ctrl[3*8 +: 8], 8'h00);
        // R10 start mid-byte
        bus_start();
        send_byte(8'hC0, 0, 0, ack);
        send_byte(8'h03, 0, 0, ack);
        send_bits(8'hFF, 5);
        bus_start();
        send_byte(8'hC0, 0, 0, ack); check("R10 restart addr ack", ack, 1);
        send_byte(8'h03, 0, 0, ack);
        send_byte(8'h77, 1, 4'h3, ack); check("R10 restart data ack", ack, 1);
        bus_stop();
        check("R10 restart reg3", ctrl[3*8 +: 8], 8'h77);

        // R9 sleep
        sleep = 1;
        tick(2);
        write_regs("R9", 4'h2, '{8'h00});
        check("R9 reg2 kept", ctrl[2*8 +: 8], 8'h5A);
        sleep = 0;
        tick(2);

        // R7 soft clear with a pending divider half
        write_regs("R7", 4'h0, '{8'h33});
        write_regs("R7", 4'hF, '{8'h40});
        check("R7 regF", ctrl[15*8 +: 8], 8'h80);
        check("R7 reg2", ctrl[2*8 +: 8], 8'h00);
        check("R7 div cleared", div, 0);
        write_regs("R7", 4'h1, '{8'h44});
        tick(4);
        check("R7 pending half dropped", div, 0);
        read_regs("R7", 4'hF, 1);

        tick(10);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule